// File: doc/BRIEF.md
# Master Interrupt Gate with Sampled Acknowledge

This block collects level interrupt indications from several lower-level sources and merges them into one interrupt line. Each source has a pending bit. The pending bit sets whenever its source is high and stays set until software acknowledges it. A master enable bit gates the output line. The enable and the pending bits sit in one register, so a single read returns both and a single write can change both.

Software services an interrupt in four steps:

1. It writes zero to drop the master enable, which silences the line.
2. It reads the register to get a snapshot of the pending sources.
3. It writes that snapshot back, with the enable bit clear, to acknowledge exactly those bits.
4. It writes the enable bit to re-arm the gate.

A source that is still active, or that fired during servicing, remains pending. It therefore raises the line again as soon as the gate is re-armed. A final write of all ones clears every idle pending bit and arms the gate. This is the last step of a reset sequence, so that lower levels cannot re-latch stale bits.

A two-level hierarchy uses one instance per tile for the per-unit registers and one more instance above them. In the upper instance, each tile's interrupt output drives one source bit. Software then services only the tiles whose bit it reads as set.

Top module: `master_irq_gate`

## Requirements
- R1: After reset the enable bit is 0, all pending bits are 0, the read value is 0 and the interrupt output is low.
- R2: A source input that is high at a clock edge sets its pending bit at that edge, whether the master enable is set or clear.
- R3: A pending bit stays set after its source falls, for as long as no write acknowledges it.
- R4: A write whose data has bit i set (i below the source count) clears pending bit i, provided source i is low in that cycle. Bits written as 0 keep their value.
- R5: Every write loads the master enable from data bit 31: writing 0 disables the gate, and a write with bit 31 set enables it. Cycles without a write leave the enable unchanged.
- R6: The interrupt output is high exactly when the master enable is set and at least one pending bit is set.
- R7: The read data carries the enable in bit 31 and pending bit i in bit i, with all other bits 0. It is valid in the same cycle and needs no read strobe.
- R8: A source that is high in the cycle its bit is acknowledged keeps that bit set, so re-arming the gate raises the interrupt again.
- R9: Writing all ones clears every pending bit whose source is low and sets the master enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | SRC_W | Level indications from lower-level sources |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data: bit 31 is the enable, low bits are write-one-to-acknowledge |
| rd_data | output | DATA_W | Register read value: enable in bit 31, pending bits in the low bits |
| irq_o | output | 1 | Gated interrupt line |

## Verification
The bench aims at three timing cases.

The first is a source that is still high in the cycle it is acknowledged. A design that lets the acknowledge win would lose that event, and the line would stay quiet after the gate is re-armed.

The second is disabling the gate while bits are pending. A design that wrongly clears pending bits on disable, or that keeps the line up, shows a wrong read value or a stray interrupt.

The third is acknowledging a subset of bits, or writing all ones. Here a design that treats the enable and the pending bits as one field, or that clears unwritten bits, returns a wrong snapshot.

// File: rtl/master_irq_gate.sv
module master_irq_gate #(
  parameter int SRC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam int EN_BIT = DATA_W - 1;

  logic             en_q;
  logic [SRC_W-1:0] pend_q;
  logic [SRC_W-1:0] ack;
  logic             armed_q;

  assign ack = wr_en ? wr_data[SRC_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~ack) | src_i;
      armed_q <= 1'b1;
      if (wr_en) en_q <= wr_data[EN_BIT];
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[SRC_W-1:0]   = pend_q;
    rd_data[EN_BIT]      = en_q;
  end

  assign irq_o = en_q & (|pend_q);

  initial assert (SRC_W < DATA_W - 1) else $error("SRC_W must leave bit %0d free", EN_BIT);

  assert_src_latches_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    1'b1 |=> ((pend_q & $past(src_i)) == $past(src_i)));

  assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !wr_en |=> ((rd_data[SRC_W-1:0] & $past(rd_data[SRC_W-1:0])) == $past(rd_data[SRC_W-1:0])));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    wr_en |=> ((rd_data[SRC_W-1:0] & $past(wr_data[SRC_W-1:0] & ~src_i)) == '0));

  assert_enable_load_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    wr_en |=> (rd_data[EN_BIT] == $past(wr_data[EN_BIT])));

  assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !wr_en |=> $stable(rd_data[EN_BIT]));

  assert_gate_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[EN_BIT] |-> !irq_o);

  assert_refire_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (wr_en && wr_data[EN_BIT] && (|src_i)) |=> irq_o);
endmodule

// File: tb/master_irq_gate_test.sv
module master_irq_gate_test;
  localparam int SRC_W  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SRC_W-1:0]  src_i = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq_o;

  int checks = 0;
  int fails  = 0;
  logic             m_en = 1'b0;
  logic [SRC_W-1:0] m_pend = '0;

  always #5 clk = ~clk;

  master_irq_gate #(.SRC_W(SRC_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [DATA_W-1:0] exp_rd();
    logic [DATA_W-1:0] v = '0;
    v[SRC_W-1:0] = m_pend;
    v[DATA_W-1]  = m_en;
    return v;
  endfunction

  function automatic logic exp_irq();
    return m_en && (m_pend != '0);
  endfunction

  task automatic check(input string req);
    checks++;
    if (rd_data !== exp_rd()) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, exp_rd());
    end else if (irq_o !== exp_irq()) begin
      fails++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, irq_o, exp_irq());
    end
  endtask

  task automatic step(input logic [SRC_W-1:0] s, input logic we,
                      input logic [DATA_W-1:0] wd, input string req);
    src_i = s; wr_en = we; wr_data = wd;
    @(posedge clk);
    m_pend = (m_pend & ~(we ? wd[SRC_W-1:0] : '0)) | s;
    if (we) m_en = wd[DATA_W-1];
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    step(8'h05, 1'b0, '0, "R2");
    step(8'h00, 1'b0, '0, "R3");
    step(8'h00, 1'b0, '0, "R3");
    step(8'h00, 1'b1, 32'h8000_0000, "R5");
    step(8'h00, 1'b0, '0, "R6");
    step(8'h00, 1'b1, 32'h0, "R5");
    step(8'h00, 1'b0, '0, "R7");
    step(8'h00, 1'b1, 32'h0000_0001, "R4");
    step(8'h20, 1'b0, '0, "R2");
    step(8'h04, 1'b1, 32'h0000_0024, "R8");
    step(8'h00, 1'b1, 32'h8000_0000, "R8");
    step(8'h00, 1'b1, 32'h0000_0004, "R4");
    step(8'h00, 1'b0, '0, "R6");
    step(8'hFF, 1'b0, '0, "R2");
    step(8'h10, 1'b1, 32'hFFFF_FFFF, "R9");
    step(8'h00, 1'b1, 32'hFFFF_FFFF, "R9");
    step(8'h00, 1'b1, 32'h0000_00FF, "R5");

    for (int i = 0; i < 3000; i++) begin
      logic [SRC_W-1:0] s;
      logic [DATA_W-1:0] wd;
      logic we;
      s  = SRC_W'($urandom & $urandom & $urandom);
      we = ($urandom % 3) == 0;
      wd = $urandom;
      if (($urandom % 2) == 0) wd = {$urandom % 2 == 0, 23'd0, exp_rd()[SRC_W-1:0]};
      step(s, we, wd, "R6/R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule